// File: doc/BRIEF.md
# Real-Time Clock Interrupt Output Controller

This block drives the single active-low interrupt pin of a real-time clock. Three events can request an interrupt: the alarm match, the countdown timer expiry and the watchdog timeout. Each arrives as a one-cycle set strobe from logic outside the block. The block latches each into a sticky flag. Each source has its own enable. The pin is low while at least one enabled source is requesting.

The alarm and the watchdog always request as a level that follows their flag. The countdown source has a mode bit. In level mode it follows its flag. In pulse mode each expiry produces a pulse of fixed length, and a new expiry during the pulse restarts it.

A narrow register-write port updates the enables and clears the alarm and countdown flags. The serial front end supplies the address and data. It raises `wr_commit` for one cycle at the eighth bit clock of the command byte, and the write takes effect on that edge. Clearing a flag, or dropping an enable, therefore ends the interrupt right away. The watchdog flag cannot be cleared through this port. Only the watchdog's own restart strobe clears it. No data stream crosses this block, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset `irq_n` is 1. All three flags are 0. All enables, the countdown mode bit and the watchdog control field are 0.
- R2: With the alarm enable set (address 0, bit 0), `irq_n` goes low in the cycle after `alarm_set`. It stays low for as long as the alarm flag is set.
- R3: A commit to address 1 with bit 0 equal to 0 clears the alarm flag. `irq_n` is high directly after that edge if no other source is requesting. A commit with bit 0 equal to 1 leaves the alarm flag unchanged.
- R4: In pulse mode (address 0, bit 2 = 1) with the countdown enable set (address 0, bit 1), `cd_set` drives `irq_n` low for exactly PULSE_LEN cycles. PULSE_LEN is 64 by default.
- R5: A `cd_set` during an active pulse restarts the pulse. `irq_n` then stays low for PULSE_LEN cycles counted from the new event.
- R6: In pulse mode, a commit to address 1 with bit 1 equal to 0 clears the countdown flag and ends the pulse at that edge.
- R7: In level mode (address 0, bit 2 = 0), the countdown request follows the countdown flag for as long as the flag stays set. A commit that writes the countdown enable to 0 releases `irq_n` at that edge.
- R8: The watchdog requests as a level that follows its flag, but only while the two-bit control field at address 2, bits 1:0, is nonzero. When the field is 0 the flag has no effect on `irq_n`.
- R9: No register write changes the watchdog flag. Only `wd_restart` clears it.
- R10: Flags are set-dominant. A set strobe and a clear in the same cycle leave the flag set.
- R11: `irq_n` is the active-low OR of all enabled requests. It is released only when no enabled source requests.
- R12: A source whose enable is 0 still latches its flag but does not pull `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_set | input | 1 | One-cycle strobe: minute counter reached the alarm value |
| cd_set | input | 1 | One-cycle strobe: countdown timer expired |
| wd_set | input | 1 | One-cycle strobe: watchdog timed out |
| wd_restart | input | 1 | One-cycle strobe: watchdog restarted, clears its flag |
| wr_commit | input | 1 | Eighth-bit-clock strobe that applies the write |
| wr_addr | input | 2 | Register address of the write |
| wr_data | input | 8 | Write data |
| irq_n | output | 1 | Active-low interrupt pin |
| alarm_flag | output | 1 | Alarm flag state |
| cd_flag | output | 1 | Countdown flag state |
| wd_flag | output | 1 | Watchdog flag state |

## Verification
The assertions take for granted that every input is synchronous to `clk`. They also assume `wr_addr` and `wr_data` are valid in any cycle where `wr_commit` is high. A same-cycle set and clear is legal and must resolve to set. The bench drives all inputs on the falling edge and holds each strobe for exactly one cycle. It clears every flag and returns the enables to a known state before each scenario, so no leftover request hides or fakes a release of `irq_n`.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int NSRC   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_WDCTL = 2'd2;

  localparam int BIT_ALARM = 0;
  localparam int BIT_CD    = 1;
  localparam int BIT_MODE  = 2;

  typedef enum logic [1:0] {
    SRC_ALARM = 2'd0,
    SRC_CD    = 2'd1,
    SRC_WD    = 2'd2
  } src_e;

  typedef struct packed {
    logic       alarm_ie;
    logic       cd_ie;
    logic       cd_pulse;
    logic [1:0] wd_sel;
  } ctrl_t;
endpackage

// File: rtl/rtcirq_flag.sv
module rtcirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  a_r10_set_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r3_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/rtcirq_regs.sv
module rtcirq_regs
  import rtcirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl_o,
  output logic              alarm_clr_o,
  output logic              cd_clr_o
);
  logic wr_ctrl, wr_flags, wr_wd;
  logic unused_data;

  assign wr_ctrl  = wr_commit && (wr_addr == ADDR_CTRL);
  assign wr_flags = wr_commit && (wr_addr == ADDR_FLAGS);
  assign wr_wd    = wr_commit && (wr_addr == ADDR_WDCTL);
  assign unused_data = ^wr_data[DATA_W-1:BIT_MODE+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_o.alarm_ie <= wr_data[BIT_ALARM];
        ctrl_o.cd_ie    <= wr_data[BIT_CD];
        ctrl_o.cd_pulse <= wr_data[BIT_MODE];
      end
      if (wr_wd) ctrl_o.wd_sel <= wr_data[1:0];
    end
  end

  // writing 0 clears, writing 1 leaves the flag alone
  assign alarm_clr_o = wr_flags && !wr_data[BIT_ALARM];
  assign cd_clr_o    = wr_flags && !wr_data[BIT_CD];

  a_r7_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_o.cd_ie == $past(wr_data[BIT_CD])));
endmodule

// File: rtl/rtcirq_cd_pulse.sv
module rtcirq_cd_pulse #(
  parameter int PULSE_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic abort_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LEN = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load_i)     cnt <= LEN;
    else if (abort_i)    cnt <= '0;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active_o = (cnt != '0);

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !load_i && !abort_i) |=> (cnt == $past(cnt) - 1'b1));
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> active_o);
  a_r6_cut_short: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !load_i) |=> !active_o);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtcirq_pkg::*;
#(
  parameter int PULSE_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm_set,
  input  logic              cd_set,
  input  logic              wd_set,
  input  logic              wd_restart,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_n,
  output logic              alarm_flag,
  output logic              cd_flag,
  output logic              wd_flag
);
  ctrl_t            ctrl;
  logic             alarm_clr, cd_clr;
  logic [NSRC-1:0]  set_vec, clr_vec, flag_vec, req_vec;
  logic             pulse_active;

  rtcirq_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_commit  (wr_commit),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctrl_o     (ctrl),
    .alarm_clr_o(alarm_clr),
    .cd_clr_o   (cd_clr)
  );

  assign set_vec[SRC_ALARM] = alarm_set;
  assign set_vec[SRC_CD]    = cd_set;
  assign set_vec[SRC_WD]    = wd_set;
  assign clr_vec[SRC_ALARM] = alarm_clr;
  assign clr_vec[SRC_CD]    = cd_clr;
  assign clr_vec[SRC_WD]    = wd_restart;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    rtcirq_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_vec[i]),
      .clr_i(clr_vec[i]),
      .q_o  (flag_vec[i])
    );
  end

  rtcirq_cd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cd_set),
    .abort_i (cd_clr),
    .active_o(pulse_active)
  );

  assign req_vec[SRC_ALARM] = ctrl.alarm_ie & flag_vec[SRC_ALARM];
  assign req_vec[SRC_CD]    = ctrl.cd_ie &
                              (ctrl.cd_pulse ? pulse_active : flag_vec[SRC_CD]);
  assign req_vec[SRC_WD]    = (ctrl.wd_sel != 2'b00) & flag_vec[SRC_WD];

  assign irq_n      = ~|req_vec;
  assign alarm_flag = flag_vec[SRC_ALARM];
  assign cd_flag    = flag_vec[SRC_CD];
  assign wd_flag    = flag_vec[SRC_WD];

  a_r2_alarm_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.alarm_ie && alarm_flag) |-> !irq_n);
  a_r7_cd_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.cd_ie && !ctrl.cd_pulse && cd_flag) |-> !irq_n);
  a_r8_wd_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl.wd_sel != 2'b00) && wd_flag) |-> !irq_n);
  a_r9_wd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_flag && !wd_restart) |=> wd_flag);
  a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.alarm_ie && !ctrl.cd_ie && (ctrl.wd_sel == 2'b00)) |-> irq_n);
endmodule

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;
  localparam int PLEN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alarm_set = 0, cd_set = 0, wd_set = 0, wd_restart = 0;
  logic wr_commit = 0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic irq_n, alarm_flag, cd_flag, wd_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_irq_ctrl #(.PULSE_LEN(PLEN)) uut (
    .clk(clk), .rst_n(rst_n), .alarm_set(alarm_set), .cd_set(cd_set),
    .wd_set(wd_set), .wd_restart(wd_restart), .wr_commit(wr_commit),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_n(irq_n),
    .alarm_flag(alarm_flag), .cd_flag(cd_flag), .wd_flag(wd_flag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_commit = 1;
    @(negedge clk);
    wr_commit = 0;
  endtask

  task automatic strobe(ref logic s);
    s = 1;
    @(negedge clk);
    s = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_low(output int n);
    n = 0;
    for (int i = 0; i < PLEN + 40; i++) begin
      if (!irq_n) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 irq_n", irq_n, 1);
    chk("R1 alarm_flag", alarm_flag, 0);
    chk("R1 cd_flag", cd_flag, 0);
    chk("R1 wd_flag", wd_flag, 0);
    wd_set = 1; alarm_set = 1; cd_set = 1;
    @(negedge clk);
    wd_set = 0; alarm_set = 0; cd_set = 0;
    chk("R1 enables off, irq_n", irq_n, 1);
    reg_write(2'd1, 8'h00);
    strobe(wd_restart);
  endtask

  task automatic t_alarm();
    reg_write(2'd0, 8'h01);
    strobe(alarm_set);
    chk("R2 alarm irq_n", irq_n, 0);
    idle(5);
    chk("R2 alarm level held", irq_n, 0);
    reg_write(2'd1, 8'hFF);
    chk("R3 write 1 keeps alarm_flag", alarm_flag, 1);
    chk("R3 write 1 keeps irq", irq_n, 0);
    reg_write(2'd1, 8'hFE);
    chk("R3 clear alarm_flag", alarm_flag, 0);
    chk("R3 clear releases irq", irq_n, 1);
    reg_write(2'd0, 8'h00);
  endtask

  task automatic t_disabled();
    strobe(alarm_set);
    chk("R12 flag latched", alarm_flag, 1);
    chk("R12 irq_n quiet", irq_n, 1);
    reg_write(2'd1, 8'h00);
  endtask

  task automatic t_cd_pulse();
    int n;
    reg_write(2'd0, 8'h06);
    strobe(cd_set);
    count_low(n);
    chk("R4 pulse length", n, PLEN);
    chk("R4 flag kept after pulse", cd_flag, 1);
    reg_write(2'd1, 8'hFD);
  endtask

  task automatic t_retrigger();
    int n;
    strobe(cd_set);
    idle(29);
    chk("R5 still in first pulse", irq_n, 0);
    strobe(cd_set);
    count_low(n);
    chk("R5 restarted pulse length", n, PLEN);
    reg_write(2'd1, 8'hFD);
  endtask

  task automatic t_cut();
    int n;
    strobe(cd_set);
    idle(9);
    reg_write(2'd1, 8'hFD);
    chk("R6 pulse cut at clear", irq_n, 1);
    chk("R6 cd_flag cleared", cd_flag, 0);
    count_low(n);
    chk("R6 no remaining pulse", n, 0);
  endtask

  task automatic t_cd_level();
    int n;
    reg_write(2'd0, 8'h02);
    strobe(cd_set);
    chk("R7 level asserted", irq_n, 0);
    count_low(n);
    chk("R7 level held past pulse length", n, PLEN + 40);
    reg_write(2'd0, 8'h00);
    chk("R7 enable off releases", irq_n, 1);
    chk("R7 flag survives enable off", cd_flag, 1);
    reg_write(2'd1, 8'h00);
  endtask

  task automatic t_wd();
    strobe(wd_set);
    chk("R8 field 0 gates", irq_n, 1);
    chk("R8 wd_flag latched", wd_flag, 1);
    reg_write(2'd2, 8'h02);
    chk("R8 field nonzero asserts", irq_n, 0);
    reg_write(2'd1, 8'h00);
    reg_write(2'd2, 8'h03);
    chk("R9 write leaves wd_flag", wd_flag, 1);
    chk("R9 irq still low", irq_n, 0);
    strobe(wd_restart);
    chk("R9 restart clears wd_flag", wd_flag, 0);
    chk("R9 restart releases irq", irq_n, 1);
  endtask

  task automatic t_set_dom();
    reg_write(2'd0, 8'h01);
    alarm_set = 1; wr_addr = 2'd1; wr_data = 8'h00; wr_commit = 1;
    @(negedge clk);
    alarm_set = 0; wr_commit = 0;
    chk("R10 set wins", alarm_flag, 1);
    chk("R10 irq held", irq_n, 0);
    reg_write(2'd1, 8'h00);
    chk("R10 later clear", alarm_flag, 0);
  endtask

  task automatic t_or();
    strobe(alarm_set);
    strobe(wd_set);
    reg_write(2'd1, 8'hFE);
    chk("R11 wd keeps irq after alarm clear", irq_n, 0);
    strobe(wd_restart);
    chk("R11 released when none", irq_n, 1);
    reg_write(2'd0, 8'h00);
    reg_write(2'd2, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alarm();
    t_disabled();
    t_cd_pulse();
    t_retrigger();
    t_cut();
    t_cd_level();
    t_wd();
    t_set_dom();
    t_or();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule